// File: doc/BRIEF.md
# Parallel Host Register Port with Selectable Bus Width

This block is the slave side of a parallel microcontroller bus for an audio mixing engine. A host reaches it through an active-low chip select, write strobe and read strobe, an 8-bit byte address and a 32-bit data path. The data path is split into an input, an output and an output-enable, so the pad ring can build the tri-state driver. Two strap pins fix the host bus width at 8, 16 or 32 bits. Every internal register is 32 bits wide. In the narrow modes the two low address bits pick the halfword or byte lane of a register that the access reaches.

The block holds an 8-bit control word and a word of match thresholds. It also holds a delay word with three fields and 32 signed 24-bit mixing coefficients in lane-split memories. Two read-only words pass status from the datapath back to the host. Clearing bit 0 of the control word starts a coefficient wipe that takes one cycle per coefficient. The bit reads back as 1 again when the wipe ends, and all other settings stay as they were. The strobes are asynchronous to the block clock. They go through a synchronizer, and a write commits when the synchronized write strobe rises while chip select is low.

Top module: `mcu_regport`

## Requirements
- R1: After reset the control word reads 0000008Bh, the thresholds word reads 00076543h, the delay word reads 00152B6Bh (fields 6:0 = 107, 14:8 = 43, 20:16 = 21), and every coefficient reads 0 once the reset wipe has ended.
- R2: Strap bit 1 = 1 selects a 32-bit bus whatever strap bit 0 is: DATA[31:0] carries register bits 31:0 and address bits 1:0 are ignored.
- R3: Strap = 01 selects a 16-bit bus: address bit 1 = 0 maps register bits 15:0 and = 1 maps bits 31:16, both onto DATA[15:0]; DATA[31:16] reads 0.
- R4: Strap = 00 selects an 8-bit bus: address bits 1:0 = k map register bits 8k+7:8k onto DATA[7:0]; DATA[31:8] reads 0.
- R5: A write commits on the rising edge of the write strobe while chip select is low; write strobe pulses with chip select high change nothing.
- R6: data_oe is 1 only while chip select and read strobe are both low (after the synchronizer delay) and 0 otherwise; data_out is 0 whenever data_oe is 0.
- R7: Control bits 7:1 are read/write; writing 0 to bit 0 (byte lane 0 enabled) starts a wipe of 32 cycles during which bit 0 reads 0; it reads 1 afterwards.
- R8: The wipe sets all coefficients at 80h-FFh to 0, keeps the control, threshold and delay words, and drops host coefficient writes that arrive while it runs.
- R9: Addresses 04h-07h read stat_word and 0Ch-0Fh read match_word; host writes there have no effect.
- R10: Addresses 14h-7Fh read 0 and ignore writes; control bits 31:8, threshold bits 31:20, delay bits 7, 15 and 31:21, and coefficient bits 31:24 always read 0.
- R11: coef_val shows the coefficient selected by coef_idx one clock after coef_idx is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_strap | input | 2 | Bus width strap (1x = 32, 01 = 16, 00 = 8 bits) |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low, commit on rising edge |
| rd_n | input | 1 | Read strobe, active low |
| addr | input | 8 | Byte address |
| data_in | input | 32 | Host write data from the pad |
| data_out | output | 32 | Read data to the pad |
| data_oe | output | 1 | Pad output enable |
| stat_word | input | 32 | Switching status from the datapath |
| match_word | input | 32 | Measured match counts from the datapath |
| cfg_ctrl | output | 8 | Control word, bit 0 high when no wipe runs |
| cfg_match | output | 20 | Match thresholds |
| dly_fast | output | 7 | Delay for the high sample rate |
| dly_slow | output | 7 | Delay for the low sample rate |
| dly_down | output | 5 | Delay for the down-conversion path |
| coef_idx | input | 5 | Datapath coefficient select |
| coef_val | output | 24 | Selected coefficient, registered |
| wipe_busy | output | 1 | High while the coefficient wipe runs |

## Verification
If the lane decoder is wrong, a write lands in a neighbouring byte or halfword. The next read of that register then shows the error, either in the 32-bit view or in another lane view. The sweep writes each coefficient at full width, then overwrites one halfword and one byte of it. It reads every lane back in every strap mode. A wrong wipe counter leaves nonzero coefficients or a stuck bit 0, and both show in the first reads after the wipe window. A faulty output-enable path shows at data_oe within four clocks of a strobe change.

// File: rtl/mcu_regport_pkg.sv
package mcu_regport_pkg;
  localparam int BUS_W  = 32;
  localparam int LANES  = BUS_W / 8;
  localparam int ADDR_W = 8;

  typedef enum logic [1:0] {
    BW8  = 2'd0,
    BW16 = 2'd1,
    BW32 = 2'd2
  } bus_mode_e;

  typedef struct packed {
    logic              cs_n;
    logic              wr_n;
    logic              rd_n;
    logic [ADDR_W-1:0] addr;
    logic [BUS_W-1:0]  data;
  } host_pins_t;

  function automatic bus_mode_e decode_mode(input logic [1:0] strap);
    if (strap[1])      return BW32;
    else if (strap[0]) return BW16;
    else               return BW8;
  endfunction

  function automatic logic [BUS_W-1:0] lane_bits(input logic [LANES-1:0] m);
    logic [BUS_W-1:0] r;
    for (int i = 0; i < LANES; i++) r[8*i +: 8] = {8{m[i]}};
    return r;
  endfunction
endpackage

// File: rtl/mcu_regport_sync.sv
module mcu_regport_sync
  import mcu_regport_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  host_pins_t        pins_in,
  output logic              rd_active,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_pulse,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BUS_W-1:0]  wr_data
);
  localparam int PW = $bits(host_pins_t);
  localparam host_pins_t IDLE = '{cs_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1, addr: '0, data: '0};

  logic [STAGES:0][PW-1:0] pipe;
  host_pins_t now_s, prev_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s <= STAGES; s++) pipe[s] <= IDLE;
    end else begin
      pipe[0] <= pins_in;
      for (int s = 1; s <= STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign now_s  = host_pins_t'(pipe[STAGES-1]);
  assign prev_s = host_pins_t'(pipe[STAGES]);

  assign rd_active = !now_s.cs_n && !now_s.rd_n;
  assign rd_addr   = now_s.addr;
  assign wr_pulse  = now_s.wr_n && !prev_s.wr_n && !prev_s.cs_n;
  assign wr_addr   = prev_s.addr;
  assign wr_data   = prev_s.data;

  logic unused_bits;
  assign unused_bits = ^{now_s.data, prev_s.rd_n};

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |=> !wr_pulse);
endmodule

// File: rtl/mcu_regport_lanes.sv
module mcu_regport_lanes
  import mcu_regport_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  bus_mode_e        mode,
  input  logic [1:0]       wr_lo,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [LANES-1:0] wr_mask,
  output logic [BUS_W-1:0] wr_word,
  input  logic [1:0]       rd_lo,
  input  logic [BUS_W-1:0] rd_word,
  output logic [BUS_W-1:0] bus_rdata
);
  localparam int HALF = BUS_W / 2;

  always_comb begin
    case (mode)
      BW32: begin
        wr_mask = '1;
        wr_word = bus_wdata;
      end
      BW16: begin
        wr_mask = wr_lo[1] ? 4'b1100 : 4'b0011;
        wr_word = {2{bus_wdata[HALF-1:0]}};
      end
      default: begin
        wr_mask = 4'b0001 << wr_lo;
        wr_word = {LANES{bus_wdata[7:0]}};
      end
    endcase
  end

  always_comb begin
    case (mode)
      BW32:    bus_rdata = rd_word;
      BW16:    bus_rdata = rd_lo[1] ? {{HALF{1'b0}}, rd_word[BUS_W-1:HALF]}
                                    : {{HALF{1'b0}}, rd_word[HALF-1:0]};
      default: bus_rdata = {{(BUS_W-8){1'b0}}, rd_word[8*rd_lo +: 8]};
    endcase
  end

  p_mask_shape_r2: assert property (@(posedge clk) disable iff (rst)
    ($countones(wr_mask) == 1) || ($countones(wr_mask) == 2) || ($countones(wr_mask) == 4));
endmodule

// File: rtl/mcu_regport_coefs.sv
module mcu_regport_coefs #(
  parameter int NUM = 32,
  parameter int W   = 24,
  localparam int NL = W / 8,
  localparam int IW = $clog2(NUM)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_start,
  output logic          busy,
  input  logic [NL-1:0] h_we,
  input  logic [IW-1:0] h_widx,
  input  logic [W-1:0]  h_wdata,
  input  logic [IW-1:0] h_ridx,
  output logic [W-1:0]  h_rdata,
  input  logic [IW-1:0] d_ridx,
  output logic [W-1:0]  d_rdata
);
  localparam logic [IW-1:0] LAST = IW'(NUM - 1);

  logic          busy_q;
  logic [IW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end else if (clr_start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end
  assign busy = busy_q;

  generate
    for (genvar l = 0; l < NL; l++) begin : g_lane
      logic [7:0]    mem [NUM];
      logic [7:0]    hq, dq;
      logic          we;
      logic [IW-1:0] wa;
      logic [7:0]    wd;
      assign we = busy_q || h_we[l];
      assign wa = busy_q ? cnt_q : h_widx;
      assign wd = busy_q ? 8'h00 : h_wdata[8*l +: 8];
      always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
        hq <= mem[h_ridx];
        dq <= mem[d_ridx];
      end
      assign h_rdata[8*l +: 8] = hq;
      assign d_rdata[8*l +: 8] = dq;
    end
  endgenerate

  p_wipe_span_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> ($past(cnt_q) == LAST));
  p_wipe_start_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |=> (cnt_q == IW'(1)));
endmodule

// File: rtl/mcu_regport.sv
module mcu_regport
  import mcu_regport_pkg::*;
#(
  parameter int          NUM_COEF    = 32,
  parameter int          COEF_W      = 24,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  CTRL_RESET  = 8'h8B,
  parameter logic [19:0] THR_RESET   = 20'h76543,
  parameter logic [6:0]  DLY_FAST_RESET = 7'd107,
  parameter logic [6:0]  DLY_SLOW_RESET = 7'd43,
  parameter logic [4:0]  DLY_DOWN_RESET = 5'd21
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  bus_strap,
  input  logic        cs_n,
  input  logic        wr_n,
  input  logic        rd_n,
  input  logic [7:0]  addr,
  input  logic [31:0] data_in,
  output logic [31:0] data_out,
  output logic        data_oe,
  input  logic [31:0] stat_word,
  input  logic [31:0] match_word,
  output logic [7:0]  cfg_ctrl,
  output logic [19:0] cfg_match,
  output logic [6:0]  dly_fast,
  output logic [6:0]  dly_slow,
  output logic [4:0]  dly_down,
  input  logic [4:0]  coef_idx,
  output logic [23:0] coef_val,
  output logic        wipe_busy
);
  localparam int CIW = $clog2(NUM_COEF);
  localparam int WIW = ADDR_W - 3;
  localparam logic [BUS_W-1:0] THR_MASK = 32'h000F_FFFF;
  localparam logic [BUS_W-1:0] DLY_MASK = 32'h001F_7F7F;
  localparam logic [BUS_W-1:0] DLY_INIT = {11'd0, DLY_DOWN_RESET, 1'b0, DLY_SLOW_RESET, 1'b0, DLY_FAST_RESET};
  localparam logic [WIW-1:0] W_CTRL = WIW'(0);
  localparam logic [WIW-1:0] W_STAT = WIW'(1);
  localparam logic [WIW-1:0] W_THR  = WIW'(2);
  localparam logic [WIW-1:0] W_MEAS = WIW'(3);
  localparam logic [WIW-1:0] W_DLY  = WIW'(4);

  host_pins_t        pins_raw;
  logic              rd_active, wr_pulse;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [BUS_W-1:0]  wr_data;
  bus_mode_e         mode;

  assign pins_raw = '{cs_n: cs_n, wr_n: wr_n, rd_n: rd_n, addr: addr, data: data_in};
  assign mode     = decode_mode(bus_strap);

  mcu_regport_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pins_in(pins_raw),
    .rd_active(rd_active), .rd_addr(rd_addr),
    .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  logic [LANES-1:0] wr_mask;
  logic [BUS_W-1:0] wr_word, bm, rd_word, bus_rdata;
  logic [1:0]       rd_lo_q;

  mcu_regport_lanes u_lanes (
    .clk(clk), .rst(rst), .mode(mode),
    .wr_lo(wr_addr[1:0]), .bus_wdata(wr_data),
    .wr_mask(wr_mask), .wr_word(wr_word),
    .rd_lo(rd_lo_q), .rd_word(rd_word), .bus_rdata(bus_rdata)
  );
  assign bm = lane_bits(wr_mask);

  // register file
  logic [7:1]       ctrl_hi_q;
  logic [BUS_W-1:0] thr_q, dly_q;
  logic             busy;
  logic             wr_regs, wr_coef, clr_start;
  logic [WIW-1:0]   wr_widx;
  logic [BUS_W-1:0] ctrl_new;

  assign wr_widx   = wr_addr[ADDR_W-2:2];
  assign wr_regs   = wr_pulse && !wr_addr[ADDR_W-1];
  assign wr_coef   = wr_pulse &&  wr_addr[ADDR_W-1] && !busy;
  assign ctrl_new  = ({24'd0, ctrl_hi_q, 1'b1} & ~bm) | (wr_word & bm);
  assign clr_start = wr_regs && (wr_widx == W_CTRL) && wr_mask[0] && !wr_word[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_hi_q <= CTRL_RESET[7:1];
      thr_q     <= {12'd0, THR_RESET};
      dly_q     <= DLY_INIT;
    end else if (wr_regs) begin
      case (wr_widx)
        W_CTRL:  ctrl_hi_q <= ctrl_new[7:1];
        W_THR:   thr_q <= ((thr_q & ~bm) | (wr_word & bm)) & THR_MASK;
        W_DLY:   dly_q <= ((dly_q & ~bm) | (wr_word & bm)) & DLY_MASK;
        default: ;
      endcase
    end
  end

  logic [COEF_W-1:0] h_rdata;

  mcu_regport_coefs #(.NUM(NUM_COEF), .W(COEF_W)) u_coefs (
    .clk(clk), .rst(rst), .clr_start(clr_start), .busy(busy),
    .h_we(wr_coef ? wr_mask[COEF_W/8-1:0] : '0),
    .h_widx(wr_addr[CIW+1:2]), .h_wdata(wr_word[COEF_W-1:0]),
    .h_ridx(rd_addr[CIW+1:2]), .h_rdata(h_rdata),
    .d_ridx(coef_idx), .d_rdata(coef_val)
  );

  // read pipeline: stage A selects the word, stage B steers and drives
  logic             rd_act_q, rd_coef_q;
  logic [BUS_W-1:0] rd_reg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act_q  <= 1'b0;
      rd_coef_q <= 1'b0;
      rd_lo_q   <= '0;
      rd_reg_q  <= '0;
    end else begin
      rd_act_q  <= rd_active;
      rd_coef_q <= rd_addr[ADDR_W-1];
      rd_lo_q   <= rd_addr[1:0];
      case (rd_addr[ADDR_W-2:2])
        W_CTRL:  rd_reg_q <= {24'd0, ctrl_hi_q, !busy};
        W_STAT:  rd_reg_q <= stat_word;
        W_THR:   rd_reg_q <= thr_q;
        W_MEAS:  rd_reg_q <= match_word;
        W_DLY:   rd_reg_q <= dly_q;
        default: rd_reg_q <= '0;
      endcase
    end
  end

  assign rd_word = rd_coef_q ? BUS_W'(h_rdata) : rd_reg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_oe  <= 1'b0;
      data_out <= '0;
    end else begin
      data_oe  <= rd_act_q;
      data_out <= rd_act_q ? bus_rdata : '0;
    end
  end

  assign cfg_ctrl  = {ctrl_hi_q, !busy};
  assign cfg_match = thr_q[19:0];
  assign dly_fast  = dly_q[6:0];
  assign dly_slow  = dly_q[14:8];
  assign dly_down  = dly_q[20:16];
  assign wipe_busy = busy;

  logic unused_bits;
  assign unused_bits = ^{thr_q[31:20], dly_q[31:21], dly_q[15], dly_q[7], wr_word[31:24]};

  p_oe_needs_read_r6: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> $past(rd_active, 2));
  p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(wr_regs && wr_widx == W_CTRL) |=> $stable(ctrl_hi_q));
  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (rst)
    ((dly_q & ~DLY_MASK) == '0) && ((thr_q & ~THR_MASK) == '0));
  p_wipe_keeps_cfg_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !wr_regs) |=> ($stable(thr_q) && $stable(dly_q)));
endmodule

// File: tb/mcu_regport_test.sv
module mcu_regport_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_strap = 2'b10;
  logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0]  addr = 8'h00;
  logic [31:0] data_in = 32'h0;
  logic [31:0] data_out;
  logic        data_oe;
  logic [31:0] stat_word  = 32'h9070_4101;
  logic [31:0] match_word = 32'h3456_7654;
  logic [7:0]  cfg_ctrl;
  logic [19:0] cfg_match;
  logic [6:0]  dly_fast, dly_slow;
  logic [4:0]  dly_down;
  logic [4:0]  coef_idx = 5'd0;
  logic [23:0] coef_val;
  logic        wipe_busy;

  always #2.5 clk = ~clk;

  mcu_regport uut (
    .clk(clk), .rst(rst), .bus_strap(bus_strap), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .stat_word(stat_word), .match_word(match_word), .cfg_ctrl(cfg_ctrl), .cfg_match(cfg_match),
    .dly_fast(dly_fast), .dly_slow(dly_slow), .dly_down(dly_down),
    .coef_idx(coef_idx), .coef_val(coef_val), .wipe_busy(wipe_busy)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model
  logic [7:0]  ctrl_m = 8'h8A;
  logic [31:0] thr_m  = 32'h0007_6543;
  logic [31:0] dly_m  = 32'h0015_2B6B;
  logic [23:0] coef_m [32];
  bit          model_off = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [7:0] a);
    if (a[7]) return {8'h00, coef_m[a[6:2]]};
    case (a[6:2])
      5'd0: return {24'h0, ctrl_m | 8'h01};
      5'd1: return stat_word;
      5'd2: return thr_m;
      5'd3: return match_word;
      5'd4: return dly_m;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] steer(input logic [1:0] s, input logic [1:0] lo, input logic [31:0] w);
    if (s[1]) return w;
    if (s[0]) return lo[1] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
    return {24'h0, w[8*lo +: 8]};
  endfunction

  task automatic model_write(input logic [1:0] s, input logic [7:0] a, input logic [31:0] d);
    logic [3:0] m;
    logic [31:0] w, bm, old;
    if (s[1]) begin m = 4'hF; w = d; end
    else if (s[0]) begin m = a[1] ? 4'hC : 4'h3; w = {2{d[15:0]}}; end
    else begin m = 4'b0001 << a[1:0]; w = {4{d[7:0]}}; end
    for (int i = 0; i < 4; i++) bm[8*i +: 8] = {8{m[i]}};
    if (model_off) return;
    if (a[7]) begin
      old = {8'h0, coef_m[a[6:2]]};
      coef_m[a[6:2]] = 24'((old & ~bm) | (w & bm));
    end else begin
      case (a[6:2])
        5'd0: begin
          old = {24'h0, ctrl_m | 8'h01};
          ctrl_m = 8'((old & ~bm) | (w & bm)) & 8'hFE;
          if (m[0] && !w[0]) for (int i = 0; i < 32; i++) coef_m[i] = 24'h0;
        end
        5'd2: thr_m = ((thr_m & ~bm) | (w & bm)) & 32'h000F_FFFF;
        5'd4: dly_m = ((dly_m & ~bm) | (w & bm)) & 32'h001F_7F7F;
        default: ;
      endcase
    end
  endtask

  task automatic bus_write(input logic [1:0] s, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_strap = s; addr = a; data_in = d; cs_n = 0;
    repeat (3) @(negedge clk);
    wr_n = 0;
    repeat (4) @(negedge clk);
    wr_n = 1;
    repeat (3) @(negedge clk);
    cs_n = 1;
    repeat (3) @(negedge clk);
    model_write(s, a, d);
  endtask

  task automatic bus_read(input logic [1:0] s, input logic [7:0] a,
                          output logic [31:0] got, output logic oe);
    @(negedge clk);
    bus_strap = s; addr = a; cs_n = 0; rd_n = 0;
    repeat (8) @(negedge clk);
    got = data_out; oe = data_oe;
    rd_n = 1; cs_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic read_check(input string tag, input logic [1:0] s, input logic [7:0] a);
    logic [31:0] got;
    logic oe;
    bus_read(s, a, got, oe);
    chk(tag, got, steer(s, a[1:0], exp_word(a)));
  endtask

  initial begin
    logic [31:0] got;
    logic oe;
    for (int i = 0; i < 32; i++) coef_m[i] = 24'h0;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (45) @(negedge clk);

    // R1 reset values
    chk("R6 idle oe", {31'h0, data_oe}, 32'h0);
    bus_read(2'b10, 8'h00, got, oe);
    chk("R1 ctrl", got, 32'h0000_008B);
    chk("R6 oe during read", {31'h0, oe}, 32'h1);
    chk("R6 oe after read", {31'h0, data_oe}, 32'h0);
    bus_read(2'b10, 8'h08, got, oe);
    chk("R1 thr", got, 32'h0007_6543);
    bus_read(2'b10, 8'h10, got, oe);
    chk("R1 dly", got, 32'h0015_2B6B);
    chk("R1 dly fields", {9'h0, dly_down, dly_slow, dly_fast, 4'h0}, {9'h0, 5'd21, 7'd43, 7'd107, 4'h0});
    for (int i = 0; i < 32; i++) read_check("R1 coef zero", 2'b10, 8'h80 + 8'(4*i));

    // R2 R3 R4 lane sweep over every coefficient
    for (int i = 0; i < 32; i++) begin
      logic [31:0] p;
      logic [7:0] a;
      p = (32'(i) * 32'h0137_5B29) ^ 32'hC3A5_6E17;
      a = 8'h80 + 8'(4*i);
      bus_write((i % 2 == 0) ? 2'b10 : 2'b11, a, p);
      bus_write(2'b01, a | {6'h0, i[0], 1'b0}, {p[7:0], p[31:24]} ^ 16'h5AA5);
      bus_write(2'b00, a | {6'h0, 2'(i >> 1)}, p[15:8] ^ 8'h3C);
    end
    for (int i = 0; i < 32; i++) begin
      logic [7:0] a;
      a = 8'h80 + 8'(4*i);
      read_check("R2 32-bit strap 10", 2'b10, a);
      read_check("R2 32-bit strap 11", 2'b11, a | 8'h03);
      read_check("R3 16-bit low", 2'b01, a);
      read_check("R3 16-bit high", 2'b01, a | 8'h02);
      for (int k = 0; k < 4; k++) read_check("R4 8-bit lane", 2'b00, a | 8'(k));
    end

    // R11 datapath coefficient port
    for (int i = 0; i < 32; i += 5) begin
      @(negedge clk);
      coef_idx = 5'(i);
      @(negedge clk);
      chk("R11 coef port", {8'h0, coef_val}, {8'h0, coef_m[i]});
    end

    // R9 status words
    read_check("R9 stat", 2'b10, 8'h04);
    read_check("R9 meas", 2'b11, 8'h0C);
    read_check("R9 stat byte", 2'b00, 8'h06);
    read_check("R9 meas half", 2'b01, 8'h0E);
    model_off = 1;
    bus_write(2'b10, 8'h04, 32'h1234_5678);
    bus_write(2'b10, 8'h0C, 32'hFFFF_FFFF);
    model_off = 0;
    read_check("R9 stat after write", 2'b10, 8'h04);
    read_check("R9 meas after write", 2'b10, 8'h0C);

    // R10 unmapped and reserved bits
    for (int a = 8'h14; a < 8'h80; a += 4) read_check("R10 unmapped", 2'b10, 8'(a));
    bus_write(2'b10, 8'h40, 32'hFFFF_FFFF);
    read_check("R10 unmapped after write", 2'b10, 8'h40);
    bus_write(2'b10, 8'h10, 32'hFFFF_FFFF);
    bus_read(2'b10, 8'h10, got, oe);
    chk("R10 dly reserved", got, 32'h001F_7F7F);
    bus_write(2'b10, 8'h08, 32'hFFFF_FFFF);
    bus_read(2'b10, 8'h08, got, oe);
    chk("R10 thr reserved", got, 32'h000F_FFFF);
    bus_write(2'b10, 8'h00, 32'hFFFF_FFFF);
    bus_read(2'b10, 8'h00, got, oe);
    chk("R10 ctrl reserved", got, 32'h0000_00FF);
    bus_write(2'b10, 8'hFC, 32'hFFFF_FFFF);
    bus_read(2'b10, 8'hFC, got, oe);
    chk("R10 coef top byte", got, 32'h00FF_FFFF);
    bus_write(2'b10, 8'h08, 32'h0001_2345);
    bus_write(2'b10, 8'h10, 32'h000A_3A5A);

    // R5 write strobe without chip select
    @(negedge clk);
    bus_strap = 2'b10; addr = 8'h08; data_in = 32'h0;
    repeat (2) @(negedge clk);
    wr_n = 0;
    repeat (4) @(negedge clk);
    wr_n = 1;
    repeat (4) @(negedge clk);
    read_check("R5 no cs no write", 2'b10, 8'h08);
    chk("R5 thr output", {12'h0, cfg_match}, 32'h0001_2345);

    // R6 read strobe without chip select
    @(negedge clk);
    addr = 8'h08; rd_n = 0;
    repeat (8) @(negedge clk);
    chk("R6 no cs no drive", {31'h0, data_oe}, 32'h0);
    chk("R6 data quiet", data_out, 32'h0);
    rd_n = 1;
    repeat (3) @(negedge clk);

    // R7 R8 wipe via 32-bit write
    bus_write(2'b10, 8'h00, 32'h0000_0034);
    bus_read(2'b10, 8'h00, got, oe);
    chk("R7 bit0 low during wipe", got, 32'h0000_0034);
    repeat (40) @(negedge clk);
    bus_read(2'b10, 8'h00, got, oe);
    chk("R7 bit0 back high", got, 32'h0000_0035);
    read_check("R8 thr kept", 2'b10, 8'h08);
    read_check("R8 dly kept", 2'b10, 8'h10);
    for (int i = 0; i < 32; i++) read_check("R8 coef cleared", 2'b10, 8'h80 + 8'(4*i));

    // R8 coefficient write during wipe is dropped; wipe from 8-bit bus
    bus_write(2'b10, 8'h94, 32'h0012_3456);
    read_check("R8 coef set before wipe", 2'b10, 8'h94);
    bus_write(2'b00, 8'h00, 32'h0000_008A);
    model_off = 1;
    bus_write(2'b10, 8'h98, 32'h0065_4321);
    model_off = 0;
    repeat (40) @(negedge clk);
    read_check("R8 coef wiped", 2'b10, 8'h94);
    read_check("R8 write during wipe dropped", 2'b10, 8'h98);
    read_check("R7 ctrl after byte wipe", 2'b10, 8'h00);

    // R7 byte write to lane 1 of control never starts a wipe
    bus_write(2'b00, 8'h01, 32'h0000_0000);
    chk("R7 lane1 no wipe", {31'h0, wipe_busy}, 32'h0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule